// File: doc/BRIEF.md
# Flash Operation Command Sequencer

This block turns one software-issued flash command into a run of word-level requests toward a flash back end. Software first writes a byte start address, then a command word holding the operation, the erase scope, the partition and a word count. The start bit in that word launches the run. While the run is active, the block locks its own command and address registers. It walks the word addresses, sends program data taken from a small internal program FIFO, and forwards read data to a downstream sink. At the end it raises sticky done or error flags, and these also drive interrupt lines.

The start address is cut down before use, and the cut depends on the operation. Reads and programs align to a bus word. A page erase aligns to a page, and a bank erase aligns to a bank. A failed word, or a command with an illegal operation code, stops the run, sets the error flag and records a 9-bit word index.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command word layout: bit 0 is start, bits 2:1 are the operation (0 read, 1 program, 2 erase, 3 illegal), bit 3 is the erase scope (0 page, 1 bank), bit 4 is the partition (0 data, 1 info), and bits 27:16 are the count. Register index 0 is the command, 1 is the start address and 2 is the status. Each flash request carries the launched operation on `fl_op`, the partition on `fl_part` and the erase scope on `fl_erase_bank`.
- R2: A read or program with count N issues N+1 requests at consecutive word addresses, 4 bytes apart. An erase issues exactly one request and ignores the count.
- R3: The first request address is the start address rounded down: to 4 bytes for read and program, to 2048 bytes for page erase, and to 524288 bytes for bank erase.
- R4: The status bit 2 write-enable flag reads 1 when idle and 0 while a run is active. While it is 0, writes to the command and address registers and any start bit are ignored.
- R5: Status bit 0 (done) and bit 1 (error) stay set until software writes 1 to that bit of the status register. `irq_done` and `irq_err` follow those two flags.
- R6: `prog_wready` is 1 only while a program run is active and the FIFO has room. Data offered at other times is not taken.
- R7: A request answered with `fl_err` ends the run with no further requests. It sets the error flag, leaves done clear, and stores the failing byte address divided by 4, truncated to 9 bits, in status bits 24:16.
- R8: Each successful read request produces one `rd_valid` cycle, with `rd_data` equal to the flash word returned.
- R9: A start with operation code 3 issues no request, sets the error flag, and stores the word index of the start address in status bits 24:16.
- R10: After reset the status reads 0x4, the command register reads 0, and `fl_req`, `prog_wready`, `irq_done` and `irq_err` are 0.
- R11: Program words reach `fl_wdata` in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| prog_wvalid | input | 1 | Program word offered |
| prog_wdata | input | 32 | Program word |
| prog_wready | output | 1 | Program word taken this cycle |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| fl_req | output | 1 | Flash request, held until acknowledged |
| fl_op | output | 2 | Request operation |
| fl_part | output | 1 | Request partition |
| fl_erase_bank | output | 1 | Request erase scope |
| fl_addr | output | 32 | Request byte address |
| fl_wdata | output | 32 | Request program data |
| fl_ack | input | 1 | Flash acknowledge |
| fl_rdata | input | 32 | Flash read data |
| fl_err | input | 1 | Flash error, valid with acknowledge |
| irq_done | output | 1 | Operation-done interrupt |
| irq_err | output | 1 | Operation-error interrupt |

## Verification
The sequencer state shows up directly on the flash port. A wrong remaining count or a wrong step appears as an extra, missing or misplaced `fl_addr` at the first or last acknowledge of a run. A wrong alignment mask shows on the very first request, one cycle after the start write. A busy flag that sticks or drops too early is visible through status bit 2 and through command writes that do or do not take effect. A stale or overflowing program FIFO shows as wrong `fl_wdata` on the next program run.

// File: rtl/flash_seq_pkg.sv
// Shared encodings for the flash command sequencer.
// Assumes a 32-bit register port.
package flash_seq_pkg;

    localparam int CNT_W = 12;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } flash_op_e;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    typedef struct packed {
        flash_op_e        op;
        logic             erase_bank;
        logic             part_info;
        logic [CNT_W-1:0] count;
    } cmd_t;

    // Decode a command register write into its fields.
    function automatic cmd_t unpack_cmd(input logic [31:0] w);
        cmd_t c;
        c.op         = flash_op_e'(w[2:1]);
        c.erase_bank = w[3];
        c.part_info  = w[4];
        c.count      = w[16 +: CNT_W];
        return c;
    endfunction

endpackage

// File: rtl/flash_cmd_regs.sv
// Command, address and status registers with hardware lock.
// Assumes busy comes from the sequencer and fin_* are single-cycle pulses.
module flash_cmd_regs
    import flash_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int EADDR_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               busy,
    input  logic               fin_ok,
    input  logic               fin_err,
    input  logic [EADDR_W-1:0] err_addr_in,
    output logic               start_req,
    output cmd_t               cmd_new,
    output logic [AW-1:0]      addr_q,
    output logic               done_q,
    output logic               err_q
);

    logic               ctrl_wen;
    logic               wr_cmd, wr_addr, wr_stat;
    cmd_t               cmd_q;
    logic [EADDR_W-1:0] eaddr_q;

    assign ctrl_wen  = !busy;
    assign wr_cmd    = reg_we && (reg_addr == REG_CMD) && ctrl_wen;
    assign wr_addr   = reg_we && (reg_addr == REG_ADDR) && ctrl_wen;
    assign wr_stat   = reg_we && (reg_addr == REG_STAT);
    assign start_req = wr_cmd && reg_wdata[0];
    assign cmd_new   = unpack_cmd(reg_wdata);

    // Hold command fields and start address; writes are ignored while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= cmd_new;
            if (wr_addr) addr_q <= reg_wdata[AW-1:0];
        end
    end

    // Sticky done/error flags: set by hardware, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            eaddr_q <= '0;
        end else begin
            done_q <= fin_ok  | (done_q & ~(wr_stat & reg_wdata[0]));
            err_q  <= fin_err | (err_q  & ~(wr_stat & reg_wdata[1]));
            if (fin_err) eaddr_q <= err_addr_in;
        end
    end

    // Register readback.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CMD: begin
                reg_rdata[0]             = busy;
                reg_rdata[2:1]           = cmd_q.op;
                reg_rdata[3]             = cmd_q.erase_bank;
                reg_rdata[4]             = cmd_q.part_info;
                reg_rdata[16 +: CNT_W]   = cmd_q.count;
            end
            REG_ADDR: reg_rdata[AW-1:0]  = addr_q;
            REG_STAT: begin
                reg_rdata[0]             = done_q;
                reg_rdata[1]             = err_q;
                reg_rdata[2]             = ctrl_wen;
                reg_rdata[16 +: EADDR_W] = eaddr_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !(wr_stat && reg_wdata[1]) |=> err_q);

    assert_wen_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (fin_ok || fin_err) |=> ctrl_wen);

endmodule

// File: rtl/flash_addr_align.sv
// Rounds the start address down to word, page or bank granularity.
// Assumes all sizes are powers of two.
module flash_addr_align
    import flash_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    parameter int PAGE_BYTES = 2048,
    parameter int BANK_PAGES = 256
) (
    input  flash_op_e     op,
    input  logic          erase_bank,
    input  logic [AW-1:0] raw_addr,
    output logic [AW-1:0] aligned
);

    localparam int WORD_LSB = $clog2(WORD_BYTES);
    localparam int PAGE_LSB = $clog2(PAGE_BYTES);
    localparam int BANK_LSB = $clog2(PAGE_BYTES * BANK_PAGES);
    localparam logic [AW-1:0] WORD_MASK = {AW{1'b1}} << WORD_LSB;
    localparam logic [AW-1:0] PAGE_MASK = {AW{1'b1}} << PAGE_LSB;
    localparam logic [AW-1:0] BANK_MASK = {AW{1'b1}} << BANK_LSB;

    // Pick the mask that matches the operation granularity.
    always_comb begin
        if (op == OP_ERASE) aligned = raw_addr & (erase_bank ? BANK_MASK : PAGE_MASK);
        else                aligned = raw_addr & WORD_MASK;
    end

endmodule

// File: rtl/flash_prog_fifo.sv
// Small program-data FIFO, emptied and closed while flush is high.
// Assumes DEPTH is a power of two and pop is only raised when not empty.
module flash_prog_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          not_empty
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          push;

    assign push_ready = !flush && (count != CW'(DEPTH));
    assign push       = push_valid && push_ready;
    assign not_empty  = (count != '0);
    assign head       = mem[rptr];

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + PW'(1);
            if (pop)  rptr <= rptr + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !not_empty);

    assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);

endmodule

// File: rtl/flash_word_seq.sv
// Walks word addresses of one launched command and finishes it.
// Assumes the flash side holds ack for one cycle per request.
module flash_word_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    parameter int EADDR_W    = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  cmd_t               cmd_new,
    input  logic [AW-1:0]      start_addr,
    output logic               busy,
    output flash_op_e          op_q,
    output logic               fl_req,
    output logic               fl_part,
    output logic               fl_erase_bank,
    output logic [AW-1:0]      fl_addr,
    input  logic               fl_ack,
    input  logic               fl_err,
    input  logic               fifo_has,
    output logic               fifo_pop,
    output logic               prog_active,
    output logic               rd_fire,
    output logic               fin_ok,
    output logic               fin_err,
    output logic [EADDR_W-1:0] err_addr
);

    localparam int WORD_LSB = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic             busy_q, part_q, bank_q;
    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] left_q;
    logic             launch, reject, accept, last;

    assign launch   = start_req && (cmd_new.op != OP_BAD);
    assign reject   = start_req && (cmd_new.op == OP_BAD);
    assign fl_req   = busy_q && ((op_q != OP_PROG) || fifo_has);
    assign accept   = fl_req && fl_ack;
    assign last     = (op_q == OP_ERASE) || (left_q == '0);

    assign busy          = busy_q;
    assign fl_part       = part_q;
    assign fl_erase_bank = bank_q;
    assign fl_addr       = addr_q;
    assign prog_active   = busy_q && (op_q == OP_PROG);
    assign fifo_pop      = accept && (op_q == OP_PROG);
    assign rd_fire       = accept && (op_q == OP_READ) && !fl_err;
    assign fin_ok        = accept && !fl_err && last;
    assign fin_err       = (accept && fl_err) || reject;
    assign err_addr      = reject ? EADDR_W'(start_addr >> WORD_LSB)
                                  : EADDR_W'(addr_q >> WORD_LSB);

    // Launch a run, step per acknowledged word, stop on last word or error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= OP_READ;
            part_q <= 1'b0;
            bank_q <= 1'b0;
            addr_q <= '0;
            left_q <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            op_q   <= cmd_new.op;
            part_q <= cmd_new.part_info;
            bank_q <= cmd_new.erase_bank;
            addr_q <= start_addr;
            left_q <= cmd_new.count;
        end else if (accept) begin
            if (fl_err || last) begin
                busy_q <= 1'b0;
            end else begin
                addr_q <= addr_q + STEP;
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req && $stable(fl_addr));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (op_q != OP_ERASE) |-> (fl_addr[WORD_LSB-1:0] == '0));

    assert_no_req_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |=> !fl_req);

endmodule

// File: rtl/flash_cmd_seq.sv
// Top: register port, address alignment, program FIFO and word sequencer.
// Assumes the read sink always takes rd_data when rd_valid is high.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4,
    parameter int PAGE_BYTES = 2048,
    parameter int BANK_PAGES = 256,
    parameter int FIFO_DEPTH = 4,
    parameter int EADDR_W    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          prog_wvalid,
    input  logic [DW-1:0] prog_wdata,
    output logic          prog_wready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          fl_req,
    output logic [1:0]    fl_op,
    output logic          fl_part,
    output logic          fl_erase_bank,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic          fl_ack,
    input  logic [DW-1:0] fl_rdata,
    input  logic          fl_err,
    output logic          irq_done,
    output logic          irq_err
);

    logic               busy, start_req, fin_ok, fin_err;
    logic               fifo_has, fifo_pop, prog_active;
    logic               done_q, err_q;
    logic [EADDR_W-1:0] err_addr;
    logic [AW-1:0]      addr_q, start_addr;
    cmd_t               cmd_new;
    flash_op_e          op_q;

    flash_cmd_regs #(.AW(AW), .EADDR_W(EADDR_W)) u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .fin_ok, .fin_err, .err_addr_in(err_addr),
        .start_req, .cmd_new, .addr_q, .done_q, .err_q
    );

    flash_addr_align #(.AW(AW), .WORD_BYTES(WORD_BYTES),
                       .PAGE_BYTES(PAGE_BYTES), .BANK_PAGES(BANK_PAGES)) u_align (
        .op(cmd_new.op), .erase_bank(cmd_new.erase_bank),
        .raw_addr(addr_q), .aligned(start_addr)
    );

    flash_prog_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk, .rst_n, .flush(!prog_active),
        .push_valid(prog_wvalid), .push_data(prog_wdata), .push_ready(prog_wready),
        .pop(fifo_pop), .head(fl_wdata), .not_empty(fifo_has)
    );

    flash_word_seq #(.AW(AW), .WORD_BYTES(WORD_BYTES), .EADDR_W(EADDR_W)) u_seq (
        .clk, .rst_n, .start_req, .cmd_new, .start_addr,
        .busy, .op_q, .fl_req, .fl_part, .fl_erase_bank, .fl_addr,
        .fl_ack, .fl_err, .fifo_has, .fifo_pop, .prog_active,
        .rd_fire(rd_valid), .fin_ok, .fin_err, .err_addr
    );

    assign fl_op    = op_q;
    assign rd_data  = fl_rdata;
    assign irq_done = done_q;
    assign irq_err  = err_q;

    assert_rd_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> fl_ack && (fl_op == OP_READ));

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        prog_wvalid = 1'b0;
    logic [31:0] prog_wdata = '0;
    logic        prog_wready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        fl_req, fl_part, fl_erase_bank;
    logic [1:0]  fl_op;
    logic [31:0] fl_addr, fl_wdata;
    logic        fl_ack = 1'b0;
    logic [31:0] fl_rdata = '0;
    logic        fl_err = 1'b0;
    logic        irq_done, irq_err;

    always #5 clk = ~clk;

    flash_cmd_seq u_dut (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .prog_wvalid, .prog_wdata, .prog_wready, .rd_valid, .rd_data,
        .fl_req, .fl_op, .fl_part, .fl_erase_bank, .fl_addr, .fl_wdata,
        .fl_ack, .fl_rdata, .fl_err, .irq_done, .irq_err
    );

    localparam logic [31:0] PAT = 32'hA5A5_0000;
    // Vectors: command word, raw address, expected requests, expected first address.
    localparam int NV = 6;
    localparam logic [31:0] V_CMD   [NV] = '{32'h0000_0001, 32'h0003_0001, 32'h0005_0005,
                                            32'h0000_000D, 32'h0002_0003, 32'h0001_0011};
    localparam logic [31:0] V_ADDR  [NV] = '{32'h13, 32'h1006, 32'h12345,
                                            32'h9ABCD, 32'h203, 32'h7FFFF};
    localparam int          V_N     [NV] = '{1, 4, 1, 1, 3, 2};
    localparam logic [31:0] V_FIRST [NV] = '{32'h10, 32'h1004, 32'h12000,
                                            32'h80000, 32'h200, 32'h7FFFC};

    int tests = 0;
    int fails = 0;
    logic [31:0] err_at = 32'hFFFF_FFFF;
    logic [31:0] q_addr [64];
    logic [1:0]  q_op   [64];
    logic        q_part [64];
    logic        q_bank [64];
    logic [31:0] q_wdat [64];
    logic [31:0] r_dat  [64];
    int n_req = 0;
    int n_rd = 0;

    // Flash model: acknowledge each request one cycle after it is seen.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (fl_ack) begin
                fl_ack = 1'b0;
                fl_err = 1'b0;
            end else if (fl_req) begin
                if (n_req < 64) begin
                    q_addr[n_req] = fl_addr;
                    q_op[n_req]   = fl_op;
                    q_part[n_req] = fl_part;
                    q_bank[n_req] = fl_erase_bank;
                    q_wdat[n_req] = fl_wdata;
                end
                n_req++;
                fl_rdata = fl_addr ^ PAT;
                fl_err   = (fl_addr == err_at);
                fl_ack   = 1'b1;
            end
        end
    end

    // Read sink monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                if (n_rd < 64) r_dat[n_rd] = rd_data;
                n_rd++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 500; i++) begin
            reg_read(2'd2, s);
            if (s[2]) return;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic push_words(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            prog_wdata  = base + 32'(i);
            prog_wvalid = 1'b1;
            while (!prog_wready) begin
                @(posedge clk);
                #1;
            end
            @(posedge clk);
            #1;
        end
        prog_wvalid = 1'b0;
    endtask

    task automatic clear_logs();
        n_req = 0;
        n_rd  = 0;
    endtask

    initial begin
        logic [31:0] s;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R10 reset state
        reg_read(2'd2, s); chk("R10 status", s, 32'h4);
        reg_read(2'd0, s); chk("R10 cmd", s, 32'h0);
        chk("R10 outputs", {28'h0, fl_req, prog_wready, irq_done, irq_err}, 32'h0);

        // Table walk: R1 R2 R3 R8 R11
        for (int v = 0; v < NV; v++) begin
            clear_logs();
            reg_write(2'd1, V_ADDR[v]);
            reg_write(2'd0, V_CMD[v]);
            if (V_CMD[v][2:1] == 2'd1) push_words(V_N[v], 32'h1111_0000);
            wait_idle();
            repeat (2) @(posedge clk);
            #1;
            chk("R2 request count", 32'(n_req), 32'(V_N[v]));
            chk("R3 first address", q_addr[0], V_FIRST[v]);
            chk("R2 last address", q_addr[V_N[v]-1], V_FIRST[v] + 32'(4 * (V_N[v] - 1)));
            chk("R1 op field", {30'h0, q_op[0]}, {30'h0, V_CMD[v][2:1]});
            chk("R1 partition/bank", {30'h0, q_part[0], q_bank[0]},
                {30'h0, V_CMD[v][4], V_CMD[v][3]});
            reg_read(2'd2, s);
            chk("R5 done set", {30'h0, s[1:0]}, 32'h1);
            if (V_CMD[v][2:1] == 2'd0) begin
                chk("R8 read beats", 32'(n_rd), 32'(V_N[v]));
                for (int j = 0; j < V_N[v]; j++)
                    chk("R8 read data", r_dat[j], q_addr[j] ^ PAT);
            end
            if (V_CMD[v][2:1] == 2'd1) begin
                for (int j = 0; j < V_N[v]; j++)
                    chk("R11 program order", q_wdat[j], 32'h1111_0000 + 32'(j));
            end
            reg_write(2'd2, 32'h3);
        end

        // R4 lock during a run
        clear_logs();
        reg_write(2'd1, 32'h100);
        reg_write(2'd0, 32'h0005_0001);
        reg_read(2'd2, s); chk("R4 wen low while busy", {31'h0, s[2]}, 32'h0);
        reg_write(2'd0, 32'h000F_0001);
        reg_write(2'd1, 32'h500);
        reg_read(2'd0, s); chk("R4 cmd count kept", {20'h0, s[27:16]}, 32'h5);
        reg_read(2'd1, s); chk("R4 addr kept", s, 32'h100);
        wait_idle();
        repeat (4) @(posedge clk);
        #1;
        chk("R4 single run length", 32'(n_req), 32'd6);
        reg_read(2'd2, s); chk("R4 wen back", {31'h0, s[2]}, 32'h1);
        chk("R5 irq_done", {31'h0, irq_done}, 32'h1);
        repeat (5) @(posedge clk);
        #1;
        reg_read(2'd2, s); chk("R5 done sticky", {31'h0, s[0]}, 32'h1);
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, s); chk("R5 done cleared", {30'h0, s[1:0]}, 32'h0);
        chk("R5 irq_done cleared", {31'h0, irq_done}, 32'h0);

        // R7 error mid-run
        clear_logs();
        err_at = 32'h108;
        reg_write(2'd1, 32'h100);
        reg_write(2'd0, 32'h0007_0001);
        wait_idle();
        repeat (4) @(posedge clk);
        #1;
        chk("R7 stop after error", 32'(n_req), 32'd3);
        chk("R7 good beats", 32'(n_rd), 32'd2);
        reg_read(2'd2, s);
        chk("R7 flags", {30'h0, s[1:0]}, 32'h2);
        chk("R7 error address", {23'h0, s[24:16]}, 32'h042);
        chk("R5 irq_err", {31'h0, irq_err}, 32'h1);
        reg_write(2'd2, 32'h2);
        err_at = 32'hFFFF_FFFF;

        // R9 illegal operation code
        clear_logs();
        reg_write(2'd1, 32'h806);
        reg_write(2'd0, 32'h0000_0007);
        repeat (4) @(posedge clk);
        #1;
        chk("R9 no request", 32'(n_req), 32'd0);
        reg_read(2'd2, s);
        chk("R9 flags", {29'h0, s[2:0]}, 32'h6);
        chk("R9 error address", {23'h0, s[24:16]}, 32'h001);
        reg_write(2'd2, 32'h3);

        // R6 program data gated until a program run starts
        clear_logs();
        prog_wdata  = 32'hBAD0_0000;
        prog_wvalid = 1'b1;
        repeat (3) begin
            chk("R6 ready low while idle", {31'h0, prog_wready}, 32'h0);
            @(posedge clk);
            #1;
        end
        prog_wvalid = 1'b0;
        reg_write(2'd1, 32'h40);
        reg_write(2'd0, 32'h0000_0003);
        chk("R6 no request before data", {31'h0, fl_req}, 32'h0);
        push_words(1, 32'hDEAD_0001);
        wait_idle();
        repeat (2) @(posedge clk);
        #1;
        chk("R6 only fresh word used", q_wdat[0], 32'hDEAD_0001);
        chk("R6 one request", 32'(n_req), 32'd1);
        prog_wvalid = 1'b1;
        #1;
        chk("R6 ready low after run", {31'h0, prog_wready}, 32'h0);
        prog_wvalid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule